// File: doc/BRIEF.md
# Partition Freeze Filter

This block sits on the transaction path of a host bridge and keeps a freeze state for each of 256 isolation groups. Every transaction carries an 8-bit group number. Each group owns two flags: one guards memory-mapped (MMIO) traffic and the other guards DMA and message-signalled interrupt traffic. A freeze request sets both flags of a group in one step. Software can later release each flag on its own through a clear port.

While a flag is set, traffic of its class to that group is stopped. Writes are discarded. Interrupt messages are suppressed. A read request is not sent to the bus. The block answers it itself with a completion whose data bits are all ones.

Read data coming back from the bus passes through a second path. That path replaces the data with all ones when the group has become frozen while the read was in flight. A read-back port shows both flags of any chosen group.

Top module: `part_freeze_filter`

## Requirements
- R1: After reset, both flags of every group read back as 0, and `busValid`, `fillValid` and `rspOutValid` are 0.
- R2: A freeze request for a group sets both its MMIO flag and its DMA flag at the next clock edge. The flags of all other groups stay unchanged.
- R3: `clrMmio` clears only the MMIO flag and `clrDma` clears only the DMA flag of `clrGroup`. The other flag of that group keeps its value.
- R4: If a freeze and a clear reach the same group in the same cycle, the freeze wins and both flags end up set.
- R5: A write (kind 0 = MMIO write, kind 2 = DMA write) to a group whose matching flag is set is discarded. Neither `busValid` nor `fillValid` rises for it.
- R6: A read (kind 1 = MMIO read, kind 3 = DMA read) to a group whose matching flag is set is not forwarded. One cycle later, `fillValid` is 1, `fillGroup` carries the group and `fillData` is all ones.
- R7: An interrupt message (kind 4) to a group whose DMA flag is set is suppressed. No output valid rises for it.
- R8: Kinds 0 and 1 are gated only by the MMIO flag. Kinds 2, 3 and 4 are gated only by the DMA flag.
- R9: A transaction of kinds 0 to 4 whose matching flag is clear appears on the bus one cycle later. `busKind`, `busGroup`, `busAddr` and `busData` equal the values presented.
- R10: A bus response appears on `rspOutValid` one cycle later. Its data is all ones if the group's flag is set (the DMA flag when `rspDma` is 1, otherwise the MMIO flag). If that flag is clear, the data passes through unchanged.
- R11: Kinds 5, 6 and 7 are reserved. They are never forwarded and never produce a fill completion.
- R12: A transaction presented in the same cycle as a freeze or clear of its group is gated by the flag values from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frzValid | input | 1 | Freeze request strobe |
| frzGroup | input | 8 | Group to freeze |
| clrValid | input | 1 | Clear request strobe |
| clrGroup | input | 8 | Group to clear |
| clrMmio | input | 1 | Clear the MMIO flag of clrGroup |
| clrDma | input | 1 | Clear the DMA flag of clrGroup |
| rbGroup | input | 8 | Group selected for read-back |
| rbMmio | output | 1 | MMIO flag of rbGroup |
| rbDma | output | 1 | DMA flag of rbGroup |
| txnValid | input | 1 | Incoming transaction strobe |
| txnKind | input | 3 | Transaction kind (0 MMIO wr, 1 MMIO rd, 2 DMA wr, 3 DMA rd, 4 interrupt) |
| txnGroup | input | 8 | Group of the transaction |
| txnAddr | input | 32 | Transaction address |
| txnData | input | 32 | Transaction write data |
| busValid | output | 1 | Forwarded transaction strobe |
| busKind | output | 3 | Forwarded kind |
| busGroup | output | 8 | Forwarded group |
| busAddr | output | 32 | Forwarded address |
| busData | output | 32 | Forwarded data |
| fillValid | output | 1 | Local completion for a frozen read |
| fillGroup | output | 8 | Group of the local completion |
| fillData | output | 32 | Local completion data (all ones) |
| rspValid | input | 1 | Bus read response strobe |
| rspGroup | input | 8 | Group of the response |
| rspDma | input | 1 | Response belongs to DMA traffic |
| rspData | input | 32 | Response data from the bus |
| rspOutValid | output | 1 | Filtered response strobe |
| rspOutData | output | 32 | Filtered response data |

## Verification
The bus, fill and response outputs are each due exactly one clock edge after the stimulus that causes them. The read-back outputs reflect a set or clear as soon as the edge that applied it has passed. The bench changes inputs on the falling edge and samples every output on the following falling edge, which sits half a period after the one rising edge in between. This way each check lands on the first cycle in which its result is valid. Transactions issued together with a freeze or clear are checked against the flag state from before that update.

// File: rtl/pff_pkg.sv
package pff_pkg;

  // Transaction kind codes seen on txnKind
  localparam logic [2:0] KIND_MMIO_WR = 3'd0;
  localparam logic [2:0] KIND_MMIO_RD = 3'd1;
  localparam logic [2:0] KIND_DMA_WR  = 3'd2;
  localparam logic [2:0] KIND_DMA_RD  = 3'd3;
  localparam logic [2:0] KIND_MSI     = 3'd4;

  // Strobes from the control decision to the datapath registers
  typedef struct packed {
    logic fwd;        // pass transaction to the bus
    logic fill;       // answer a frozen read locally
    logic rspLoad;    // a bus response is present
    logic rspPoison;  // replace response data with all ones
  } pff_strobe_t;

endpackage

// File: rtl/pff_flag_table.sv
module pff_flag_table #(
  parameter int GROUP_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        frzValid,
  input  logic [GROUP_W-1:0]          frzGroup,
  input  logic                        clrValid,
  input  logic [GROUP_W-1:0]          clrGroup,
  input  logic                        clrMmio,
  input  logic                        clrDma,
  output logic [(1<<GROUP_W)-1:0]     mmioFlags,
  output logic [(1<<GROUP_W)-1:0]     dmaFlags
);

  localparam int NUM_GROUPS = 1 << GROUP_W;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_entry
    logic setHit;
    logic clrHit;
    assign setHit = frzValid && (frzGroup == GROUP_W'(g));
    assign clrHit = clrValid && (clrGroup == GROUP_W'(g));

    // A freeze has priority over a clear in the same cycle
    always_ff @(posedge clk) begin
      if (!rstN) begin
        mmioFlags[g] <= 1'b0;
        dmaFlags[g]  <= 1'b0;
      end else if (setHit) begin
        mmioFlags[g] <= 1'b1;
        dmaFlags[g]  <= 1'b1;
      end else if (clrHit) begin
        if (clrMmio) mmioFlags[g] <= 1'b0;
        if (clrDma)  dmaFlags[g]  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pff_ctrl.sv
module pff_ctrl
  import pff_pkg::*;
#(
  parameter int GROUP_W = 8
) (
  input  logic                    txnValid,
  input  logic [2:0]              txnKind,
  input  logic [GROUP_W-1:0]      txnGroup,
  input  logic                    rspValid,
  input  logic [GROUP_W-1:0]      rspGroup,
  input  logic                    rspDma,
  input  logic [(1<<GROUP_W)-1:0] mmioFlags,
  input  logic [(1<<GROUP_W)-1:0] dmaFlags,
  output pff_strobe_t             strobe
);

  logic isMmio;
  logic isDmaSide;
  logic isRead;
  logic frozen;

  always_comb begin
    isMmio    = (txnKind == KIND_MMIO_WR) || (txnKind == KIND_MMIO_RD);
    isDmaSide = (txnKind == KIND_DMA_WR) || (txnKind == KIND_DMA_RD) ||
                (txnKind == KIND_MSI);
    isRead    = (txnKind == KIND_MMIO_RD) || (txnKind == KIND_DMA_RD);
    frozen    = isMmio ? mmioFlags[txnGroup] : dmaFlags[txnGroup];

    strobe.fwd       = txnValid && (isMmio || isDmaSide) && !frozen;
    strobe.fill      = txnValid && (isMmio || isDmaSide) && frozen && isRead;
    strobe.rspLoad   = rspValid;
    strobe.rspPoison = rspDma ? dmaFlags[rspGroup] : mmioFlags[rspGroup];
  end

endmodule

// File: rtl/pff_datapath.sv
module pff_datapath
  import pff_pkg::*;
#(
  parameter int GROUP_W = 8,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  pff_strobe_t        strobe,
  input  logic [2:0]         txnKind,
  input  logic [GROUP_W-1:0] txnGroup,
  input  logic [ADDR_W-1:0]  txnAddr,
  input  logic [DATA_W-1:0]  txnData,
  input  logic [DATA_W-1:0]  rspData,
  output logic               busValid,
  output logic [2:0]         busKind,
  output logic [GROUP_W-1:0] busGroup,
  output logic [ADDR_W-1:0]  busAddr,
  output logic [DATA_W-1:0]  busData,
  output logic               fillValid,
  output logic [GROUP_W-1:0] fillGroup,
  output logic [DATA_W-1:0]  fillData,
  output logic               rspOutValid,
  output logic [DATA_W-1:0]  rspOutData
);

  // Bus request stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busValid <= 1'b0;
      busKind  <= '0;
      busGroup <= '0;
      busAddr  <= '0;
      busData  <= '0;
    end else begin
      busValid <= strobe.fwd;
      if (strobe.fwd) begin
        busKind  <= txnKind;
        busGroup <= txnGroup;
        busAddr  <= txnAddr;
        busData  <= txnData;
      end
    end
  end

  // Local completion stage for frozen reads
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillValid <= 1'b0;
      fillGroup <= '0;
      fillData  <= '0;
    end else begin
      fillValid <= strobe.fill;
      fillData  <= strobe.fill ? '1 : '0;
      if (strobe.fill) fillGroup <= txnGroup;
    end
  end

  // Response substitution stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspOutValid <= 1'b0;
      rspOutData  <= '0;
    end else begin
      rspOutValid <= strobe.rspLoad;
      if (strobe.rspLoad) rspOutData <= strobe.rspPoison ? '1 : rspData;
    end
  end

endmodule

// File: rtl/part_freeze_filter.sv
module part_freeze_filter
  import pff_pkg::*;
#(
  parameter int GROUP_W = 8,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frzValid,
  input  logic [GROUP_W-1:0] frzGroup,
  input  logic               clrValid,
  input  logic [GROUP_W-1:0] clrGroup,
  input  logic               clrMmio,
  input  logic               clrDma,
  input  logic [GROUP_W-1:0] rbGroup,
  output logic               rbMmio,
  output logic               rbDma,
  input  logic               txnValid,
  input  logic [2:0]         txnKind,
  input  logic [GROUP_W-1:0] txnGroup,
  input  logic [ADDR_W-1:0]  txnAddr,
  input  logic [DATA_W-1:0]  txnData,
  output logic               busValid,
  output logic [2:0]         busKind,
  output logic [GROUP_W-1:0] busGroup,
  output logic [ADDR_W-1:0]  busAddr,
  output logic [DATA_W-1:0]  busData,
  output logic               fillValid,
  output logic [GROUP_W-1:0] fillGroup,
  output logic [DATA_W-1:0]  fillData,
  input  logic               rspValid,
  input  logic [GROUP_W-1:0] rspGroup,
  input  logic               rspDma,
  input  logic [DATA_W-1:0]  rspData,
  output logic               rspOutValid,
  output logic [DATA_W-1:0]  rspOutData
);

  localparam int NUM_GROUPS = 1 << GROUP_W;

  logic [NUM_GROUPS-1:0] mmioFlags;
  logic [NUM_GROUPS-1:0] dmaFlags;
  pff_strobe_t           strobe;

  pff_flag_table #(.GROUP_W(GROUP_W)) u_table (
    .clk(clk), .rstN(rstN),
    .frzValid(frzValid), .frzGroup(frzGroup),
    .clrValid(clrValid), .clrGroup(clrGroup),
    .clrMmio(clrMmio), .clrDma(clrDma),
    .mmioFlags(mmioFlags), .dmaFlags(dmaFlags)
  );

  pff_ctrl #(.GROUP_W(GROUP_W)) u_ctrl (
    .txnValid(txnValid), .txnKind(txnKind), .txnGroup(txnGroup),
    .rspValid(rspValid), .rspGroup(rspGroup), .rspDma(rspDma),
    .mmioFlags(mmioFlags), .dmaFlags(dmaFlags),
    .strobe(strobe)
  );

  pff_datapath #(.GROUP_W(GROUP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .txnKind(txnKind), .txnGroup(txnGroup), .txnAddr(txnAddr),
    .txnData(txnData), .rspData(rspData),
    .busValid(busValid), .busKind(busKind), .busGroup(busGroup),
    .busAddr(busAddr), .busData(busData),
    .fillValid(fillValid), .fillGroup(fillGroup), .fillData(fillData),
    .rspOutValid(rspOutValid), .rspOutData(rspOutData)
  );

  assign rbMmio = mmioFlags[rbGroup];
  assign rbDma  = dmaFlags[rbGroup];

endmodule

// File: rtl/pff_checker.sv
module pff_checker #(
  parameter int GROUP_W = 8,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               frzValid,
  input logic [GROUP_W-1:0] frzGroup,
  input logic [GROUP_W-1:0] rbGroup,
  input logic               rbMmio,
  input logic               rbDma,
  input logic               txnValid,
  input logic [2:0]         txnKind,
  input logic [GROUP_W-1:0] txnGroup,
  input logic               busValid,
  input logic [GROUP_W-1:0] busGroup,
  input logic               fillValid,
  input logic [DATA_W-1:0]  fillData,
  input logic               rspValid,
  input logic               rspOutValid
);

  AST_FREEZE_SETS_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    frzValid |=> ((rbGroup != $past(frzGroup)) || (rbMmio && rbDma))); // R2

  AST_FILL_ALL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> (&fillData)); // R6

  AST_FILL_FROM_READ: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> ($past(txnValid) &&
                   (($past(txnKind) == 3'd1) || ($past(txnKind) == 3'd3)))); // R6

  AST_BUS_FROM_TXN: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> ($past(txnValid) && ($past(txnGroup) == busGroup))); // R9

  AST_RESERVED_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (txnValid && (txnKind > 3'd4)) |=> (!busValid && !fillValid)); // R11

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> rspOutValid); // R10

  AST_RSP_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |=> !rspOutValid); // R10

endmodule

bind part_freeze_filter pff_checker #(.GROUP_W(GROUP_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .frzValid(frzValid), .frzGroup(frzGroup),
  .rbGroup(rbGroup), .rbMmio(rbMmio), .rbDma(rbDma),
  .txnValid(txnValid), .txnKind(txnKind), .txnGroup(txnGroup),
  .busValid(busValid), .busGroup(busGroup),
  .fillValid(fillValid), .fillData(fillData),
  .rspValid(rspValid), .rspOutValid(rspOutValid)
);

// File: tb/tb_part_freeze_filter.sv
module tb_part_freeze_filter;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  typedef struct packed {
    logic       frz;
    logic [7:0] fg;
    logic       clr;
    logic [7:0] cg;
    logic       cm;
    logic       cd;
    logic       tv;
    logic [2:0] tk;
    logic [7:0] tg;
    logic       eBus;
    logic       eFill;
    logic [3:0] req;
  } vec_t;

  // frz fg clr cg cm cd tv tk tg eBus eFill req
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 1'b0, 1'b1, 3'd0, 8'd5,   1'b1, 1'b0, 4'd9 },  // R9
    '{1'b1, 8'd5,   1'b0, 8'd0,   1'b0, 1'b0, 1'b1, 3'd0, 8'd5,   1'b1, 1'b0, 4'd12},  // R12
    '{1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 1'b0, 1'b1, 3'd0, 8'd5,   1'b0, 1'b0, 4'd5 },  // R5
    '{1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 1'b0, 1'b1, 3'd1, 8'd5,   1'b0, 1'b1, 4'd6 },  // R6
    '{1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 1'b0, 1'b1, 3'd2, 8'd5,   1'b0, 1'b0, 4'd5 },  // R5
    '{1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 1'b0, 1'b1, 3'd4, 8'd5,   1'b0, 1'b0, 4'd7 },  // R7
    '{1'b0, 8'd0,   1'b1, 8'd5,   1'b1, 1'b0, 1'b1, 3'd3, 8'd5,   1'b0, 1'b1, 4'd6 },  // R6
    '{1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 1'b0, 1'b1, 3'd1, 8'd5,   1'b1, 1'b0, 4'd3 },  // R3
    '{1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 1'b0, 1'b1, 3'd4, 8'd5,   1'b0, 1'b0, 4'd8 },  // R8
    '{1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 1'b0, 1'b1, 3'd0, 8'd6,   1'b1, 1'b0, 4'd2 },  // R2
    '{1'b0, 8'd0,   1'b1, 8'd5,   1'b0, 1'b1, 1'b1, 3'd2, 8'd5,   1'b0, 1'b0, 4'd12},  // R12
    '{1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 1'b0, 1'b1, 3'd4, 8'd5,   1'b1, 1'b0, 4'd3 },  // R3
    '{1'b1, 8'd255, 1'b1, 8'd255, 1'b1, 1'b1, 1'b1, 3'd3, 8'd255, 1'b1, 1'b0, 4'd12},  // R12
    '{1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 1'b0, 1'b1, 3'd3, 8'd255, 1'b0, 1'b1, 4'd4 },  // R4
    '{1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 1'b0, 1'b1, 3'd6, 8'd0,   1'b0, 1'b0, 4'd11},  // R11
    '{1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 1'b0, 1'b1, 3'd7, 8'd255, 1'b0, 1'b0, 4'd11},  // R11
    '{1'b1, 8'd0,   1'b0, 8'd0,   1'b0, 1'b0, 1'b1, 3'd2, 8'd0,   1'b1, 1'b0, 4'd12},  // R12
    '{1'b0, 8'd0,   1'b1, 8'd0,   1'b0, 1'b1, 1'b1, 3'd0, 8'd0,   1'b0, 1'b0, 4'd8 },  // R8
    '{1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 1'b0, 1'b1, 3'd2, 8'd0,   1'b1, 1'b0, 4'd8 },  // R8
    '{1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 1'b0, 1'b0, 3'd0, 8'd0,   1'b0, 1'b0, 4'd9 }   // R9
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frzValid = 1'b0;
  logic [7:0]  frzGroup = '0;
  logic        clrValid = 1'b0;
  logic [7:0]  clrGroup = '0;
  logic        clrMmio = 1'b0;
  logic        clrDma = 1'b0;
  logic [7:0]  rbGroup = '0;
  logic        rbMmio;
  logic        rbDma;
  logic        txnValid = 1'b0;
  logic [2:0]  txnKind = '0;
  logic [7:0]  txnGroup = '0;
  logic [31:0] txnAddr = '0;
  logic [31:0] txnData = '0;
  logic        busValid;
  logic [2:0]  busKind;
  logic [7:0]  busGroup;
  logic [31:0] busAddr;
  logic [31:0] busData;
  logic        fillValid;
  logic [7:0]  fillGroup;
  logic [31:0] fillData;
  logic        rspValid = 1'b0;
  logic [7:0]  rspGroup = '0;
  logic        rspDma = 1'b0;
  logic [31:0] rspData = '0;
  logic        rspOutValid;
  logic [31:0] rspOutData;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  part_freeze_filter dut (.*);

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic readback(input string req, input logic [7:0] g,
                          input logic expM, input logic expD);
    rbGroup = g;
    #1;
    check(req, $sformatf("rbMmio g%0d", g), 64'(rbMmio), 64'(expM));
    check(req, $sformatf("rbDma g%0d", g), 64'(rbDma), 64'(expD));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog all-reqs actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1", "busValid", 64'(busValid), 64'd0);
    check("R1", "fillValid", 64'(fillValid), 64'd0);
    check("R1", "rspOutValid", 64'(rspOutValid), 64'd0);
    readback("R1", 8'd0, 1'b0, 1'b0);
    readback("R1", 8'd5, 1'b0, 1'b0);
    readback("R1", 8'd255, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      frzValid = VECS[i].frz;
      frzGroup = VECS[i].fg;
      clrValid = VECS[i].clr;
      clrGroup = VECS[i].cg;
      clrMmio  = VECS[i].cm;
      clrDma   = VECS[i].cd;
      txnValid = VECS[i].tv;
      txnKind  = VECS[i].tk;
      txnGroup = VECS[i].tg;
      txnAddr  = 32'h4000_0000 + 32'(i * 16);
      txnData  = 32'hC0DE_0000 ^ 32'(i);
      @(negedge clk);
      check($sformatf("R%0d", VECS[i].req), $sformatf("busValid v%0d", i),
            64'(busValid), 64'(VECS[i].eBus));
      check($sformatf("R%0d", VECS[i].req), $sformatf("fillValid v%0d", i),
            64'(fillValid), 64'(VECS[i].eFill));
      if (VECS[i].eBus) begin
        // R9: forwarded fields unchanged
        check("R9", $sformatf("busKind v%0d", i), 64'(busKind), 64'(VECS[i].tk));
        check("R9", $sformatf("busGroup v%0d", i), 64'(busGroup), 64'(VECS[i].tg));
        check("R9", $sformatf("busAddr v%0d", i), 64'(busAddr),
              64'(32'h4000_0000 + 32'(i * 16)));
        check("R9", $sformatf("busData v%0d", i), 64'(busData),
              64'(32'hC0DE_0000 ^ 32'(i)));
      end
      if (VECS[i].eFill) begin
        // R6: local completion with all ones
        check("R6", $sformatf("fillData v%0d", i), 64'(fillData), 64'hFFFF_FFFF);
        check("R6", $sformatf("fillGroup v%0d", i), 64'(fillGroup), 64'(VECS[i].tg));
      end
    end
    frzValid = 1'b0; clrValid = 1'b0; clrMmio = 1'b0; clrDma = 1'b0; txnValid = 1'b0;

    // R3, R4, R8: final flag state
    readback("R3", 8'd5, 1'b0, 1'b0);
    readback("R4", 8'd255, 1'b1, 1'b1);
    readback("R8", 8'd0, 1'b1, 1'b0);
    readback("R2", 8'd6, 1'b0, 1'b0);

    // R10: response substitution
    rspValid = 1'b1; rspGroup = 8'd255; rspDma = 1'b1; rspData = 32'h1234_5678;
    @(negedge clk);
    check("R10", "rspOutValid frozen dma", 64'(rspOutValid), 64'd1);
    check("R10", "rspOutData frozen dma", 64'(rspOutData), 64'hFFFF_FFFF);
    rspGroup = 8'd0; rspDma = 1'b1; rspData = 32'h0BAD_F00D;
    @(negedge clk);
    check("R10", "rspOutData clear dma", 64'(rspOutData), 64'h0BAD_F00D);
    rspGroup = 8'd0; rspDma = 1'b0; rspData = 32'h5555_AAAA;
    @(negedge clk);
    check("R10", "rspOutData frozen mmio", 64'(rspOutData), 64'hFFFF_FFFF);
    rspValid = 1'b0;
    @(negedge clk);
    check("R10", "rspOutValid idle", 64'(rspOutValid), 64'd0);

    // R1: reset clears flags again
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    readback("R1", 8'd255, 1'b0, 1'b0);
    readback("R1", 8'd0, 1'b0, 1'b0);
    finish_run();
  end

endmodule